// File: doc/BRIEF.md
# Voter Fault-Masking Sweep Engine

This block measures how well a three-input majority voter hides faults, by exhaustive enumeration. The voter circuit is built into the block with a fault-flip input on every internal node. After a start pulse the engine walks through every pair of a three-bit input pattern and a nonzero internal fault mask. It evaluates one pair per clock, compares the faulted voter output with the true majority of the pattern, and counts the pairs where the output is still correct. The fault-free mask (all zero) is skipped, so it adds to neither count.

Four voter structures can be chosen through `voter_sel`, which is captured at start:
- a two-level AND/OR voter with three nodes;
- a priority-select voter with four nodes;
- an XOR-steered multiplexer voter with one node;
- a voter with an OR pre-stage and one node.

At the end of the sweep the engine raises `done` and holds the masked count and the total case count. A higher-level agent divides the two to get the masking ratio. Only the counts are produced.

Top module: `fmr_sweep_engine`

## Requirements
- R1: A synchronous active-high `rst` puts the engine into idle within one clock: `busy` = 0, `done` = 0, and both counts zero.
- R2: A `start` pulse sampled while not busy captures `voter_sel`. At the next edge `busy` rises, `done` falls and both counts are cleared to zero.
- R3: The engine evaluates exactly one case per clock. The input pattern {X,Y,Z} (X in bit 2) is the outer loop and runs 000 to 111. The fault mask is the inner loop and runs 1 to 2^k-1, where k is the node count. `busy` stays high for exactly 8*(2^k-1) cycles.
- R4: A set mask bit inverts its node, and downstream logic sees the inverted value. A case is masked when the voter output equals the majority of X, Y and Z. At the end, `total_cnt` = 8*(2^k-1).
- R5: `voter_sel` = 0 selects the AND/OR voter: node0 = X&Y, node1 = Y&Z, node2 = X&Z, output = OR of the nodes. The sweep gives 24 masked of 56.
- R6: `voter_sel` = 1 selects the priority-select voter with these nodes:
  - node0 = X^Y;
  - node1 = Y^Z;
  - node2 = NOT node1;
  - node3 = node0 & node2;
  - output = Z when node3 is set, else X.

  The sweep gives 88 masked of 120.
- R7: `voter_sel` = 2 selects the XOR-steered voter: node0 = X^Y, output = Z when node0 is set, else Y. The sweep gives 4 masked of 8, and the patterns 001, 010, 101 and 110 are the unmasked ones.
- R8: `voter_sel` = 3 selects the OR pre-stage voter: node0 = X|Y, output = node0&Z | X&Y | Y&Z. The sweep gives 6 masked of 8, and only patterns 001 and 101 are unmasked.
- R9: After a sweep, `done` stays high and both counts stay unchanged until the next start.
- R10: A `start` sampled while busy is ignored. The running sweep continues with its captured voter and its counts.
- R11: A `start` sampled while `done` is high begins a new sweep, as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (ignored while busy) |
| voter_sel | input | 2 | Voter structure, captured at start |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, counts valid |
| masked_cnt | output | CNT_W | Fault cases with a correct output |
| total_cnt | output | CNT_W | Fault cases evaluated |

## Verification
A fault in the stepping state shows at the ports as soon as the sweep ends. The sweep lasts at most 121 cycles. A fault in the stepping state shows in two ways:
- a wrong number of `busy` cycles;
- a `total_cnt` that differs from 8*(2^k-1).

A wrong node equation or a wrong fault injection shows as a wrong final masked count. For the single-node voters it is also visible case by case, because the increments of `masked_cnt` during the sweep show exactly which patterns failed. Counter or state corruption after the sweep breaks the hold of `done` and the counts within one cycle.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    localparam int PAT_W = 3;

    typedef enum logic [1:0] {
        VK_AND_OR   = 2'd0,
        VK_PRIO_MUX = 2'd1,
        VK_XOR_SEL  = 2'd2,
        VK_OR_PRE   = 2'd3
    } voter_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sweep_state_e;

    // Number of fault-injectable internal nodes per structure
    function automatic int unsigned node_count(voter_kind_e kind);
        case (kind)
            VK_AND_OR:   return 3;
            VK_PRIO_MUX: return 4;
            default:     return 1;
        endcase
    endfunction

endpackage

// File: rtl/fmr_majority_ref.sv
module fmr_majority_ref #(
    parameter int PAT_W = fmr_pkg::PAT_W
) (
    input  logic [PAT_W-1:0] pat,
    output logic             maj
);
    logic x, y, z;

    always_comb begin
        x   = pat[2];
        y   = pat[1];
        z   = pat[0];
        maj = (x & y) | (y & z) | (x & z);
    end
endmodule

// File: rtl/fmr_fault_voter.sv
module fmr_fault_voter
    import fmr_pkg::*;
#(
    parameter int PAT_W  = fmr_pkg::PAT_W,
    parameter int MASK_W = 4
) (
    input  voter_kind_e       kind,
    input  logic [PAT_W-1:0]  pat,
    input  logic [MASK_W-1:0] flip,
    output logic              vote
);
    logic x, y, z;
    logic n0, n1, n2, n3;

    always_comb begin
        x    = pat[2];
        y    = pat[1];
        z    = pat[0];
        n0   = 1'b0;
        n1   = 1'b0;
        n2   = 1'b0;
        n3   = 1'b0;
        vote = 1'b0;
        case (kind)
            VK_AND_OR: begin
                n0   = (x & y) ^ flip[0];
                n1   = (y & z) ^ flip[1];
                n2   = (x & z) ^ flip[2];
                vote = n0 | n1 | n2;
            end
            VK_PRIO_MUX: begin
                n0   = (x ^ y) ^ flip[0];
                n1   = (y ^ z) ^ flip[1];
                n2   = (~n1) ^ flip[2];
                n3   = (n0 & n2) ^ flip[3];
                vote = n3 ? z : x;
            end
            VK_XOR_SEL: begin
                n0   = (x ^ y) ^ flip[0];
                vote = n0 ? z : y;
            end
            default: begin
                n0   = (x | y) ^ flip[0];
                vote = (n0 & z) | (x & y) | (y & z);
            end
        endcase
    end
endmodule

// File: rtl/fmr_case_step.sv
module fmr_case_step
    import fmr_pkg::*;
#(
    parameter int PAT_W  = fmr_pkg::PAT_W,
    parameter int MASK_W = 4
) (
    input  voter_kind_e       kind,
    input  logic [PAT_W-1:0]  pat,
    input  logic [MASK_W-1:0] mask,
    output logic [PAT_W-1:0]  nxt_pat,
    output logic [MASK_W-1:0] nxt_mask,
    output logic              sweep_end
);
    logic [MASK_W:0]   span;
    logic [MASK_W-1:0] last_mask;
    logic              mask_wrap;

    always_comb begin
        span      = (MASK_W+1)'(1) << node_count(kind);
        last_mask = MASK_W'(span - 1'b1);
        mask_wrap = (mask == last_mask);
        nxt_mask  = mask_wrap ? MASK_W'(1) : mask + 1'b1;
        nxt_pat   = mask_wrap ? pat + 1'b1 : pat;
        sweep_end = mask_wrap && (pat == '1);
    end
endmodule

// File: rtl/fmr_sweep_engine.sv
module fmr_sweep_engine
    import fmr_pkg::*;
#(
    parameter int MAX_NODES = 4,
    parameter int CNT_W     = $clog2((1 << fmr_pkg::PAT_W) * ((1 << MAX_NODES) - 1) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       voter_sel,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] masked_cnt,
    output logic [CNT_W-1:0] total_cnt
);
    localparam int MASK_W = MAX_NODES;

    typedef struct packed {
        sweep_state_e      st;
        voter_kind_e       kind;
        logic [PAT_W-1:0]  pat;
        logic [MASK_W-1:0] mask;
        logic [CNT_W-1:0]  masked;
        logic [CNT_W-1:0]  total;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              vote_w;
    logic              maj_w;
    logic [PAT_W-1:0]  nxt_pat_w;
    logic [MASK_W-1:0] nxt_mask_w;
    logic              sweep_end_w;

    fmr_fault_voter #(.PAT_W(PAT_W), .MASK_W(MASK_W)) i_voter (
        .kind (eng_q.kind),
        .pat  (eng_q.pat),
        .flip (eng_q.mask),
        .vote (vote_w)
    );

    fmr_majority_ref #(.PAT_W(PAT_W)) i_ref (
        .pat (eng_q.pat),
        .maj (maj_w)
    );

    fmr_case_step #(.PAT_W(PAT_W), .MASK_W(MASK_W)) i_step (
        .kind      (eng_q.kind),
        .pat       (eng_q.pat),
        .mask      (eng_q.mask),
        .nxt_pat   (nxt_pat_w),
        .nxt_mask  (nxt_mask_w),
        .sweep_end (sweep_end_w)
    );

    always_comb begin
        eng_d = eng_q;
        case (eng_q.st)
            ST_RUN: begin
                eng_d.total  = eng_q.total + 1'b1;
                eng_d.masked = eng_q.masked + CNT_W'(vote_w == maj_w);
                eng_d.pat    = nxt_pat_w;
                eng_d.mask   = nxt_mask_w;
                if (sweep_end_w) begin
                    eng_d.st = ST_DONE;
                end
            end
            default: begin
                if (start) begin
                    eng_d.st     = ST_RUN;
                    eng_d.kind   = voter_kind_e'(voter_sel);
                    eng_d.pat    = '0;
                    eng_d.mask   = MASK_W'(1);
                    eng_d.masked = '0;
                    eng_d.total  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q.st     <= ST_IDLE;
            eng_q.kind   <= VK_AND_OR;
            eng_q.pat    <= '0;
            eng_q.mask   <= MASK_W'(1);
            eng_q.masked <= '0;
            eng_q.total  <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy       = (eng_q.st == ST_RUN);
    assign done       = (eng_q.st == ST_DONE);
    assign masked_cnt = eng_q.masked;
    assign total_cnt  = eng_q.total;

endmodule

// File: rtl/fmr_sweep_checker.sv
module fmr_sweep_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] masked_cnt,
    input logic [CNT_W-1:0] total_cnt
);
    // R1: reset leaves the engine idle and cleared
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && masked_cnt == '0 && total_cnt == '0));

    // R2 / R11: an accepted start clears counts and begins a sweep
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && masked_cnt == '0 && total_cnt == '0));

    // R3: one case evaluated per busy cycle
    a_r3_one_case_per_cycle: assert property (@(posedge clk) disable iff (rst)
        busy |=> (total_cnt == $past(total_cnt) + 1'b1));

    // R3: never busy and done together
    a_r3_state_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, done}));

    // R4: masked cases never exceed cases evaluated
    a_r4_masked_within_total: assert property (@(posedge clk) disable iff (rst)
        masked_cnt <= total_cnt);

    // R9: results hold while done and no start
    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(masked_cnt) && $stable(total_cnt)));

    // R10: a start while busy does not restart the sweep
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (total_cnt != '0));
endmodule

bind fmr_sweep_engine fmr_sweep_checker #(.CNT_W(CNT_W)) i_fmr_sweep_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .masked_cnt (masked_cnt),
    .total_cnt  (total_cnt)
);

// File: tb/test_fmr_sweep_engine.sv
module test_fmr_sweep_engine;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       voter_sel = 2'd0;
    logic             busy, done;
    logic [CNT_W-1:0] masked_cnt, total_cnt;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int sel;
        int masked;
        int total;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    fmr_sweep_engine i_fmr_sweep_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .voter_sel  (voter_sel),
        .busy       (busy),
        .done       (done),
        .masked_cnt (masked_cnt),
        .total_cnt  (total_cnt)
    );

    // Expected values taken from the requirements
    function automatic int exp_masked(int s);
        case (s)
            0: return 24;   // R5
            1: return 88;   // R6
            2: return 4;    // R7
            default: return 6; // R8
        endcase
    endfunction

    function automatic int exp_total(int s);
        int k;
        k = (s == 0) ? 3 : (s == 1) ? 4 : 1;
        return 8 * ((1 << k) - 1);
    endfunction

    // Bit p set: pattern p is not masked
    function automatic logic [7:0] exp_fail_map(int s);
        return (s == 2) ? 8'b0110_0110 : 8'b0010_0010;
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: pulse start, optionally push the expected result
    task automatic launch(int s, bit push);
        exp_t e;
        @(negedge clk);
        voter_sel = 2'(s);
        start = 1'b1;
        if (push) begin
            e.sel = s;
            e.masked = exp_masked(s);
            e.total = exp_total(s);
            sb_q.push_back(e);
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!done) check("R3 sweep completion", 0, 1);
    endtask

    // Monitor: follows each sweep and compares at done
    logic       prev_done = 1'b0;
    logic       prev_busy = 1'b0;
    int         prev_masked = 0;
    int         busy_samples = 0;
    int         case_idx = 0;
    logic [7:0] fail_map = 8'h00;

    always @(negedge clk) begin
        exp_t e;
        if (rst) begin
            prev_done = 1'b0;
            prev_busy = 1'b0;
            prev_masked = 0;
            busy_samples = 0;
            case_idx = 0;
            fail_map = 8'h00;
        end else begin
            if (prev_busy) begin
                if (int'(masked_cnt) == prev_masked && case_idx < 8)
                    fail_map[case_idx] = 1'b1;
                case_idx++;
            end
            if (busy) busy_samples++;
            if (done && !prev_done) begin
                if (sb_q.size() == 0) begin
                    check("R2 unexpected sweep end", 0, 1);
                end else begin
                    e = sb_q.pop_front();
                    check(tag_of(e.sel), int'(masked_cnt), e.masked);
                    check("R4 total cases", int'(total_cnt), e.total);
                    check("R3 busy cycles", busy_samples, e.total);
                    if (e.sel >= 2)
                        check(tag_of(e.sel), int'(fail_map), int'(exp_fail_map(e.sel)));
                end
                busy_samples = 0;
                case_idx = 0;
                fail_map = 8'h00;
            end
            prev_busy = busy;
            prev_masked = int'(masked_cnt);
            prev_done = done;
        end
    end

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 masked", int'(masked_cnt), 0);
        check("R1 total", int'(total_cnt), 0);

        // AND/OR voter, with a start while busy (R10)
        launch(0, 1'b1);
        check("R2 busy after start", int'(busy), 1);
        check("R2 total cleared", int'(total_cnt), 0);
        repeat (5) @(negedge clk);
        voter_sel = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R10 ignored start keeps sweep", int'(total_cnt), 56);

        // R9: results hold while done
        repeat (25) @(negedge clk);
        check("R9 done held", int'(done), 1);
        check("R9 masked held", int'(masked_cnt), 24);
        check("R9 total held", int'(total_cnt), 56);

        // R11: restart from done with the priority-select voter
        launch(1, 1'b1);
        check("R11 done cleared", int'(done), 0);
        check("R11 masked cleared", int'(masked_cnt), 0);
        wait_done();

        launch(2, 1'b1);
        wait_done();
        launch(3, 1'b1);
        wait_done();

        // R1: reset in the middle of a sweep
        launch(1, 1'b0);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid-sweep reset busy", int'(busy), 0);
        check("R1 mid-sweep reset done", int'(done), 0);
        check("R1 mid-sweep reset total", int'(total_cnt), 0);

        launch(3, 1'b1);
        wait_done();
        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", sb_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule